// File: doc/BRIEF.md
# Staged Threshold DAC Register

This block holds a 12-bit trigger threshold in two stages between a host register bus and an external DAC. The host first writes a value into a staging register. It can use a 16-bit word port, which writes the whole value in one access, or an 8-bit byte port, which takes two accesses. The value reaches the output latch that drives the DAC only when the host writes a separate load command. That write raises a one-cycle load strobe for the converter interface. Code 0x000 is the most negative threshold (-0.5 V) and 0xFFF is the most positive (+0.5 V). The scale is linear between those two codes.

On the byte port the high part must come before the low part. A high-byte write holds its nibble and marks a pair as open, shown on `busy`. The matching low-byte write completes the pair and updates the staging register. A low byte that arrives with no open pair is dropped and sets a sticky error flag. A clear command returns the sequencing logic to idle. It leaves the staged value and the output latch alone.

Each port presents a write strobe with an 8-bit sub-address and data. No bus protocol is modelled, and neither is the analog converter.

Top module: `thr_dac_stage`

## Requirements
- R1: After `rst_n` is released, `dac_code` equals the parameter `RESET_CODE` (default 0x800), and `dac_load`, `busy` and `seq_err` are 0.
- R2: A word-port write to sub-address 0x0A stores `ww_data[11:0]` into the staging register, and `ww_data[15:12]` is ignored. `dac_code` does not change until a load command.
- R3: A write to sub-address 0x09 on either port is a load command. At the clock edge that captures it, the staged value is copied into `dac_code`, and `dac_load` is 1 for exactly that one following cycle.
- R4: A byte-port write to 0x0B holds `bw_data[3:0]` as code bits 11:8 and sets `busy`. A following byte-port write to 0x0A supplies code bits 7:0, writes the composed code into the staging register and clears `busy`.
- R5: A byte-port write to 0x0A while `busy` is 0 leaves the staging register unchanged and sets `seq_err`. `seq_err` stays at 1 until a clear command or reset.
- R6: A load command issued while a byte pair is open transfers the last completed staged value and keeps the pair open, so that a later low byte still completes it.
- R7: A write to sub-address 0x08 on either port is a clear command. It clears `busy` and `seq_err` and changes neither the staging register nor `dac_code`.
- R8: When both port strobes are high in the same cycle, the word-port access is served and the byte-port access is dropped.
- R9: A word-port write to 0x0A while a byte pair is open abandons the pair: `busy` goes to 0, and a following low byte counts as orphaned (R5).
- R10: A second high-byte write before the low byte replaces the held nibble, so the pair is composed from the most recent high byte.
- R11: Writes to any other sub-address on either port change neither the staged value, `busy` nor `seq_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bw_en | input | 1 | Byte-port write strobe |
| bw_addr | input | 8 | Byte-port sub-address |
| bw_data | input | 8 | Byte-port write data |
| ww_en | input | 1 | Word-port write strobe |
| ww_addr | input | 8 | Word-port sub-address |
| ww_data | input | 16 | Word-port write data |
| dac_code | output | 12 | Output latch driving the DAC |
| dac_load | output | 1 | One-cycle strobe that marks a new `dac_code` |
| busy | output | 1 | A byte pair is open and waiting for its low byte |
| seq_err | output | 1 | Sticky flag for an orphaned low byte |

## Verification
Every write acts on the single edge that captures it. So `busy`, `seq_err` and the staging register show the result one cycle after the strobe. A load command shows up on `dac_code` and `dac_load` that same one cycle later, and `dac_load` must be low again one cycle after that. The bench drives each access on a falling edge and holds it through exactly one rising edge. It samples on the next falling edge, which is the first moment a result can be due, and for the strobe it samples again one falling edge later. The staging register can only be seen at the ports through a load, so every staging check is a load followed by a compare of `dac_code`.

// File: rtl/thr_dac_pkg.sv
package thr_dac_pkg;

  localparam int ADDR_W = 8;

  // Sub-address map; the byte port splits the value over LO/HI.
  localparam logic [ADDR_W-1:0] SUB_CLEAR = 8'h08;
  localparam logic [ADDR_W-1:0] SUB_LOAD  = 8'h09;
  localparam logic [ADDR_W-1:0] SUB_LO    = 8'h0A;
  localparam logic [ADDR_W-1:0] SUB_HI    = 8'h0B;

  // Decoded bus events; at most one is set per cycle.
  typedef struct packed {
    logic word_lo;
    logic byte_lo;
    logic byte_hi;
    logic load;
    logic clear;
  } thr_ev_t;

endpackage

// File: rtl/thr_bus_decode.sv
module thr_bus_decode
  import thr_dac_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bw_en,
  input  logic [ADDR_W-1:0] bw_addr,
  input  logic              ww_en,
  input  logic [ADDR_W-1:0] ww_addr,
  output thr_ev_t           ev
);

  // Word port has priority: a byte access in the same cycle is dropped.
  logic byte_ok;
  assign byte_ok = bw_en & ~ww_en;

  function automatic logic hit(input logic en, input logic [ADDR_W-1:0] a,
                               input logic [ADDR_W-1:0] sub);
    return en && (a == sub);
  endfunction

  always_comb begin
    ev.word_lo = hit(ww_en, ww_addr, SUB_LO);
    ev.byte_lo = hit(byte_ok, bw_addr, SUB_LO);
    ev.byte_hi = hit(byte_ok, bw_addr, SUB_HI);
    ev.load    = hit(ww_en, ww_addr, SUB_LOAD) | hit(byte_ok, bw_addr, SUB_LOAD);
    ev.clear   = hit(ww_en, ww_addr, SUB_CLEAR) | hit(byte_ok, bw_addr, SUB_CLEAR);
  end

  // R8: never more than one action per cycle
  assert_one_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev));

  // R8: with both strobes high, no byte event is produced
  assert_word_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bw_en && ww_en) |-> !(ev.byte_lo || ev.byte_hi));

endmodule

// File: rtl/thr_byte_seq.sv
module thr_byte_seq
  import thr_dac_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int BYTE_W = 8,
  localparam int HI_W  = CODE_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  thr_ev_t           ev,
  input  logic [BYTE_W-1:0] bw_data,
  output logic              pend,
  output logic              err,
  output logic              pair_done,
  output logic              orphan,
  output logic [CODE_W-1:0] pair_code
);

  logic [HI_W-1:0] hold_hi;

  function automatic logic [CODE_W-1:0] join_code(input logic [HI_W-1:0] hi,
                                                  input logic [BYTE_W-1:0] lo);
    return {hi, lo};
  endfunction

  assign pair_done = ev.byte_lo & pend;
  assign orphan    = ev.byte_lo & ~pend;
  assign pair_code = join_code(hold_hi, bw_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      err     <= 1'b0;
      hold_hi <= '0;
    end else if (ev.clear) begin
      pend <= 1'b0;
      err  <= 1'b0;
    end else begin
      if (ev.byte_hi) begin
        pend    <= 1'b1;
        hold_hi <= bw_data[HI_W-1:0];
      end else if (pair_done || ev.word_lo) begin
        pend <= 1'b0;
      end
      if (orphan) err <= 1'b1;
    end
  end

  // R4: a high byte opens a pair
  assert_busy_after_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev.byte_hi |=> pend);

  // R4: completing the pair closes it
  assert_pair_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pair_done |=> !pend);

  // R5: an orphan low byte raises the flag
  assert_orphan_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    orphan |=> err);

  // R5: the flag only rises after an orphan
  assert_err_source_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(orphan));

  // R7: clear command idles the sequencer
  assert_clear_idles_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev.clear |=> (!pend && !err));

  // R9: word write abandons an open pair
  assert_word_cancels_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev.word_lo |=> !pend);

endmodule

// File: rtl/thr_stage_reg.sv
module thr_stage_reg
  import thr_dac_pkg::*;
#(
  parameter int          CODE_W     = 12,
  parameter logic [11:0] RESET_CODE = 12'h800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  thr_ev_t           ev,
  input  logic              pair_done,
  input  logic              orphan,
  input  logic [CODE_W-1:0] word_code,
  input  logic [CODE_W-1:0] pair_code,
  output logic [CODE_W-1:0] staged
);

  always_ff @(posedge clk) begin
    if (!rst_n)              staged <= RESET_CODE[CODE_W-1:0];
    else if (ev.word_lo)     staged <= word_code;
    else if (pair_done)      staged <= pair_code;
  end

  // R5: orphan low byte leaves the staged value alone
  assert_orphan_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    orphan |=> $stable(staged));

  // R7: clear command leaves the staged value alone
  assert_clear_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev.clear |=> $stable(staged));

  // R6: a high byte alone never touches the staged value
  assert_hi_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ev.byte_hi |=> $stable(staged));

endmodule

// File: rtl/thr_out_latch.sv
module thr_out_latch #(
  parameter int          CODE_W     = 12,
  parameter logic [11:0] RESET_CODE = 12'h800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_req,
  input  logic [CODE_W-1:0] staged,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_load
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dac_code <= RESET_CODE[CODE_W-1:0];
      dac_load <= 1'b0;
    end else begin
      dac_load <= load_req;
      if (load_req) dac_code <= staged;
    end
  end

  // R3: strobe only follows a load command
  assert_strobe_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dac_load |-> $past(load_req));

  // R3: the latch takes the value staged before the edge
  assert_copy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_req |=> (dac_code == $past(staged)));

  // R2: without a load the output latch holds
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !load_req |=> $stable(dac_code));

endmodule

// File: rtl/thr_dac_stage.sv
module thr_dac_stage
  import thr_dac_pkg::*;
#(
  parameter int          CODE_W     = 12,
  parameter int          BYTE_W     = 8,
  parameter int          WORD_W     = 16,
  parameter logic [11:0] RESET_CODE = 12'h800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bw_en,
  input  logic [ADDR_W-1:0] bw_addr,
  input  logic [BYTE_W-1:0] bw_data,
  input  logic              ww_en,
  input  logic [ADDR_W-1:0] ww_addr,
  input  logic [WORD_W-1:0] ww_data,
  output logic [CODE_W-1:0] dac_code,
  output logic              dac_load,
  output logic              busy,
  output logic              seq_err
);

  thr_ev_t           ev;
  logic              pair_done;
  logic              orphan;
  logic [CODE_W-1:0] pair_code;
  logic [CODE_W-1:0] word_code;
  logic [CODE_W-1:0] staged;
  logic              unused_word_hi;

  assign word_code      = ww_data[CODE_W-1:0];
  assign unused_word_hi = ^ww_data[WORD_W-1:CODE_W];

  thr_bus_decode #(.BYTE_W(BYTE_W), .WORD_W(WORD_W)) dec_i (
    .clk(clk), .rst_n(rst_n),
    .bw_en(bw_en), .bw_addr(bw_addr),
    .ww_en(ww_en), .ww_addr(ww_addr),
    .ev(ev)
  );

  thr_byte_seq #(.CODE_W(CODE_W), .BYTE_W(BYTE_W)) seq_i (
    .clk(clk), .rst_n(rst_n), .ev(ev), .bw_data(bw_data),
    .pend(busy), .err(seq_err), .pair_done(pair_done),
    .orphan(orphan), .pair_code(pair_code)
  );

  thr_stage_reg #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) stg_i (
    .clk(clk), .rst_n(rst_n), .ev(ev),
    .pair_done(pair_done), .orphan(orphan),
    .word_code(word_code), .pair_code(pair_code),
    .staged(staged)
  );

  thr_out_latch #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) out_i (
    .clk(clk), .rst_n(rst_n), .load_req(ev.load), .staged(staged),
    .dac_code(dac_code), .dac_load(dac_load)
  );

  // R6: a load during an open pair keeps the pair open
  assert_load_keeps_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev.load && busy) |=> busy);

  // R11: an access to another sub-address changes no state
  assert_other_addr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((bw_en || ww_en) && (ev == '0)) |=> ($stable(staged) && $stable(busy) && $stable(seq_err)));

endmodule

// File: tb/thr_dac_stage_tb.sv
module thr_dac_stage_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bw_en = 1'b0;
  logic [7:0]  bw_addr = '0;
  logic [7:0]  bw_data = '0;
  logic        ww_en = 1'b0;
  logic [7:0]  ww_addr = '0;
  logic [15:0] ww_data = '0;
  logic [11:0] dac_code;
  logic        dac_load;
  logic        busy;
  logic        seq_err;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  thr_dac_stage dut_i (
    .clk(clk), .rst_n(rst_n),
    .bw_en(bw_en), .bw_addr(bw_addr), .bw_data(bw_data),
    .ww_en(ww_en), .ww_addr(ww_addr), .ww_data(ww_data),
    .dac_code(dac_code), .dac_load(dac_load), .busy(busy), .seq_err(seq_err)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic bwr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); bw_en = 1'b1; bw_addr = a; bw_data = d;
    @(negedge clk); bw_en = 1'b0;
  endtask

  task automatic wwr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); ww_en = 1'b1; ww_addr = a; ww_data = d;
    @(negedge clk); ww_en = 1'b0;
  endtask

  task automatic both(input logic [7:0] wa, input logic [15:0] wd,
                      input logic [7:0] ba, input logic [7:0] bd);
    @(negedge clk);
    ww_en = 1'b1; ww_addr = wa; ww_data = wd;
    bw_en = 1'b1; bw_addr = ba; bw_data = bd;
    @(negedge clk); ww_en = 1'b0; bw_en = 1'b0;
  endtask

  // Load, then check strobe and value, then check the strobe drops.
  task automatic load_chk(input string req, input bit via_byte, input logic [11:0] exp);
    if (via_byte) bwr(8'h09, 8'h00); else wwr(8'h09, 16'h0000);
    check({req, " load strobe"}, {15'd0, dac_load}, 16'd1);
    check({req, " dac_code"}, {4'd0, dac_code}, {4'd0, exp});
    @(negedge clk);
    check({req, " strobe one cycle"}, {15'd0, dac_load}, 16'd0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin : stim
    logic [11:0] cur;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check("R1 dac_code", {4'd0, dac_code}, 16'h0800);
    check("R1 dac_load", {15'd0, dac_load}, 16'd0);
    check("R1 busy", {15'd0, busy}, 16'd0);
    check("R1 seq_err", {15'd0, seq_err}, 16'd0);

    // R2/R3: full word-port sweep, loads alternate between ports
    cur = 12'h800;
    for (int i = 0; i < 4096; i++) begin
      logic [15:0] w;
      w = {i[3:0] ^ 4'h9, i[11:0]};
      wwr(8'h0A, w);
      if (i % 512 == 0) check("R2 no change before load", {4'd0, dac_code}, {4'd0, cur});
      if (dac_code !== cur) check("R2 no change before load", {4'd0, dac_code}, {4'd0, cur});
      load_chk("R3", i[0], i[11:0]);
      cur = i[11:0];
    end

    // R4: byte-pair sweep with garbage in the unused high nibble
    for (int c = 0; c < 4096; c += 13) begin
      logic [11:0] v;
      v = (c + 13 >= 4096) ? 12'hFFF : c[11:0];
      bwr(8'h0B, {4'hA ^ v[3:0], v[11:8]});
      check("R4 busy after high", {15'd0, busy}, 16'd1);
      bwr(8'h0A, v[7:0]);
      check("R4 busy after low", {15'd0, busy}, 16'd0);
      load_chk("R4", c[0], v);
      cur = v;
    end
    bwr(8'h0B, 8'h00); bwr(8'h0A, 8'h00);
    load_chk("R4 zero code", 1'b1, 12'h000);
    cur = 12'h000;

    // R5: orphan low byte
    wwr(8'h0A, 16'h0123); load_chk("R5 setup", 1'b0, 12'h123);
    bwr(8'h0A, 8'h55);
    check("R5 seq_err set", {15'd0, seq_err}, 16'd1);
    check("R5 busy stays low", {15'd0, busy}, 16'd0);
    load_chk("R5 staged unchanged", 1'b1, 12'h123);
    bwr(8'h0C, 8'h00);
    check("R5 seq_err sticky", {15'd0, seq_err}, 16'd1);

    // R7: clear command
    bwr(8'h08, 8'h00);
    check("R7 seq_err cleared", {15'd0, seq_err}, 16'd0);
    check("R7 dac_code kept", {4'd0, dac_code}, 16'h0123);
    bwr(8'h0B, 8'h03);
    check("R7 pair open", {15'd0, busy}, 16'd1);
    wwr(8'h08, 16'h0000);
    check("R7 busy cleared", {15'd0, busy}, 16'd0);
    check("R7 no strobe", {15'd0, dac_load}, 16'd0);
    bwr(8'h0A, 8'h44);
    check("R7 later low is orphan", {15'd0, seq_err}, 16'd1);
    load_chk("R7 staged kept", 1'b0, 12'h123);
    bwr(8'h08, 8'h00);

    // R6: load while pair half written
    bwr(8'h0B, 8'h0A); bwr(8'h0A, 8'hBC);
    bwr(8'h0B, 8'h05);
    load_chk("R6 previous value", 1'b1, 12'hABC);
    check("R6 pair still open", {15'd0, busy}, 16'd1);
    bwr(8'h0A, 8'h67);
    check("R6 no error", {15'd0, seq_err}, 16'd0);
    load_chk("R6 pair completes", 1'b0, 12'h567);

    // R8: simultaneous strobes
    both(8'h0A, 16'h0E1F, 8'h0B, 8'h07);
    check("R8 byte high dropped", {15'd0, busy}, 16'd0);
    load_chk("R8 word served", 1'b0, 12'hE1F);
    both(8'h0C, 16'h0000, 8'h09, 8'h00);
    check("R8 byte load dropped", {15'd0, dac_load}, 16'd0);

    // R9: word write cancels open pair
    bwr(8'h0B, 8'h02);
    wwr(8'h0A, 16'hF3D4);
    check("R9 busy cleared", {15'd0, busy}, 16'd0);
    bwr(8'h0A, 8'h11);
    check("R9 low is orphan", {15'd0, seq_err}, 16'd1);
    load_chk("R9 word kept", 1'b1, 12'h3D4);
    bwr(8'h08, 8'h00);

    // R10: repeated high byte
    bwr(8'h0B, 8'h01); bwr(8'h0B, 8'h07); bwr(8'h0A, 8'h22);
    load_chk("R10 latest nibble", 1'b0, 12'h722);

    // R11: other sub-addresses
    for (int a = 0; a < 256; a++) begin
      if (a >= 8 && a <= 11) continue;
      bwr(a[7:0], 8'hFF);
      wwr(a[7:0], 16'hFFFF);
      if (busy !== 1'b0 || seq_err !== 1'b0 || dac_load !== 1'b0)
        check("R11 no state change", {13'd0, busy, seq_err, dac_load}, 16'd0);
    end
    check("R11 flags idle", {14'd0, busy, seq_err}, 16'd0);
    load_chk("R11 staged kept", 1'b1, 12'h722);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule